// File: doc/BRIEF.md
# Bit-Slice Integer ALU

A combinational arithmetic logic unit for a 32-bit integer datapath. Two operands and a three-bit operation code go in. A result word, a zero flag and a signed overflow flag come out in the same cycle, with no internal state. The unit provides bitwise AND, bitwise OR, addition, subtraction and a signed set-on-less-than.

The datapath is a row of identical one-bit slices, one per result bit. Each slice holds a full adder, a conditional inverter on its b input and a small output selector. The carry passes from each slice to the next. Subtraction inverts b in every slice and feeds a carry of 1 into the lowest slice.

The zero flag lets a caller test two operands for equality by subtracting them. The overflow flag is reported to the caller and triggers nothing inside the block.

Top module: `slice_alu`

## Requirements
- R1: Operation code 3'b000 gives result = opnd_a AND opnd_b, bit for bit.
- R2: Operation code 3'b001 gives result = opnd_a OR opnd_b, bit for bit.
- R3: Operation code 3'b010 gives result = (opnd_a + opnd_b) modulo 2^32.
- R4: Operation code 3'b110 gives result = (opnd_a - opnd_b) modulo 2^32. It is formed by inverting b and forcing a carry-in of 1.
- R5: Operation code 3'b111 gives result bit 0 = 1 when opnd_a < opnd_b as signed two's complement numbers, and 0 otherwise. Bits 31..1 are 0. The comparison is correct even when the internal difference overflows.
- R6: zero is 1 exactly when all 32 result bits are 0, for every operation code.
- R7: For code 3'b010, ovf is 1 when both operands have the same sign and the sum's sign differs from it.
- R8: For code 3'b110, ovf is 1 when the operands differ in sign and the difference's sign differs from opnd_a's sign.
- R9: ovf is 0 for every code other than 3'b010 and 3'b110. It is also 0 when adding operands of opposite sign or subtracting operands of equal sign.
- R10: Codes 3'b011, 3'b100 and 3'b101 give a result of 0, so zero is 1 and ovf is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| alu_op | input | 3 | Operation code; bit 2 also selects b inversion and carry-in |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The bench builds the block at its default width of 32, so the vectors can reach the true sign-bit boundaries: 0x7FFFFFFF, 0x80000000 and all ones. These values drive the carry chain through all 32 slices. They cover both overflow directions for addition and for subtraction, and a set-on-less-than whose internal difference overflows. The unused codes get operands that would overflow under addition, which shows that those codes leave both the result and the flag at zero.

// File: rtl/slice_alu.sv
module slice_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [2:0]       alu_op,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic             negate;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum;
  logic             code_ok;
  logic             arith;
  logic             raw_ovf;
  logic             less;

  assign negate   = alu_op[2];
  assign carry[0] = negate;

  assign code_ok = (alu_op == 3'b000) || (alu_op == 3'b001) || (alu_op == 3'b010) ||
                   (alu_op == 3'b110) || (alu_op == 3'b111);
  assign arith   = (alu_op == 3'b010) || (alu_op == 3'b110);

  assign raw_ovf = carry[MSB] ^ carry[WIDTH];
  assign less    = sum[MSB] ^ raw_ovf;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic bi;
    logic slt_in;
    logic pick;
    assign bi           = opnd_b[i] ^ negate;
    assign sum[i]       = opnd_a[i] ^ bi ^ carry[i];
    assign carry[i+1]   = (opnd_a[i] & bi) | (opnd_a[i] & carry[i]) | (bi & carry[i]);
    assign slt_in       = (i == 0) ? less : 1'b0;
    always_comb begin
      unique case (alu_op[1:0])
        2'b00:   pick = opnd_a[i] & opnd_b[i];
        2'b01:   pick = opnd_a[i] | opnd_b[i];
        2'b10:   pick = sum[i];
        default: pick = slt_in;
      endcase
    end
    assign result[i] = pick & code_ok;
  end

  assign zero = ~|result;
  assign ovf  = raw_ovf & arith;
endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [2:0]       alu_op,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             ovf
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (alu_op == 3'b000)
      // R1
      and_result_chk: assert (result == (opnd_a & opnd_b));
    if (alu_op == 3'b010)
      // R3
      add_result_chk: assert (result == opnd_a + opnd_b);
    if (alu_op == 3'b110)
      // R4
      sub_result_chk: assert (result == opnd_a - opnd_b);
    if (alu_op == 3'b111)
      // R5
      slt_result_chk: assert (result == {{(WIDTH-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))});
    if (alu_op == 3'b110)
      // R6
      eq_zero_chk: assert (zero == (opnd_a == opnd_b));
    if (alu_op == 3'b010 && opnd_a[MSB] != opnd_b[MSB])
      // R9
      no_overflow_chk: assert (!ovf);
    if (alu_op == 3'b010 && opnd_a[MSB] == opnd_b[MSB])
      // R7
      add_overflow_chk: assert (ovf == (result[MSB] != opnd_a[MSB]));
    if (alu_op == 3'b110 && opnd_a[MSB] != opnd_b[MSB])
      // R8
      sub_overflow_chk: assert (ovf == (result[MSB] != opnd_a[MSB]));
    if (alu_op == 3'b011 || alu_op == 3'b100 || alu_op == 3'b101)
      // R10
      unused_code_chk: assert (result == '0 && zero && !ovf);
  end
endmodule

bind slice_alu slice_alu_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/slice_alu_tb_top.sv
module slice_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opnd_a, opnd_b, result;
  logic [2:0]  alu_op;
  logic        zero, ovf;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  slice_alu dut_i (.opnd_a(opnd_a), .opnd_b(opnd_b), .alu_op(alu_op),
                   .result(result), .zero(zero), .ovf(ovf));

  // {op, a, b, expected result, expected zero, expected ovf}
  localparam int NV = 19;
  localparam logic [100:0] VEC [NV] = '{
    {3'b000, 32'hF0F01234, 32'h0FF0FF00, 32'h00F01200, 1'b0, 1'b0}, // R1
    {3'b001, 32'hF0000000, 32'h0000000F, 32'hF000000F, 1'b0, 1'b0}, // R2
    {3'b010, 32'h00000007, 32'h00000005, 32'h0000000C, 1'b0, 1'b0}, // R3
    {3'b010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0}, // R3 R6 R9
    {3'b010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1}, // R7
    {3'b010, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1}, // R7
    {3'b110, 32'h00000010, 32'h00000003, 32'h0000000D, 1'b0, 1'b0}, // R4
    {3'b110, 32'h12345678, 32'h12345678, 32'h00000000, 1'b1, 1'b0}, // R4 R6
    {3'b110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b1}, // R8
    {3'b110, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 1'b0, 1'b1}, // R8
    {3'b110, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0}, // R9
    {3'b111, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0, 1'b0}, // R5
    {3'b111, 32'h00000005, 32'h00000003, 32'h00000000, 1'b1, 1'b0}, // R5
    {3'b111, 32'h80000000, 32'h00000001, 32'h00000001, 1'b0, 1'b0}, // R5 R9
    {3'b111, 32'h7FFFFFFF, 32'h80000000, 32'h00000000, 1'b1, 1'b0}, // R5
    {3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0}, // R10
    {3'b100, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0}, // R10
    {3'b101, 32'h000000FF, 32'h00000F00, 32'h00000000, 1'b1, 1'b0}, // R10
    {3'b000, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b0}  // R1 R9
  };

  task automatic check(input string req, input logic [33:0] got, input logic [33:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got res=%h z=%b v=%b, expected res=%h z=%b v=%b",
               req, got[33:2], got[1], got[0], exp[33:2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    alu_op = op; opnd_a = a; opnd_b = b;
    @(negedge clk);
  endtask

  initial begin
    alu_op = 3'b000; opnd_a = '0; opnd_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 reset state", {result, zero, ovf}, {32'h0, 1'b1, 1'b0});
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][100:98], VEC[i][97:66], VEC[i][65:34]);
      check($sformatf("vector %0d", i), {result, zero, ovf}, VEC[i][33:0]);
    end

    // R2 alternating pattern
    apply(3'b001, 32'hAAAA5555, 32'h5555AAAA);
    check("R2 or all ones", {result, zero, ovf}, {32'hFFFFFFFF, 1'b0, 1'b0});
    // R4 borrow through every slice
    apply(3'b110, 32'h00000000, 32'h00000001);
    check("R4 zero minus one", {result, zero, ovf}, {32'hFFFFFFFF, 1'b0, 1'b0});
    // R5 equal operands are not less
    apply(3'b111, 32'h80000000, 32'h80000000);
    check("R5 equal minint", {result, zero, ovf}, {32'h0, 1'b1, 1'b0});
    // R10 unused code after an overflowing add
    apply(3'b010, 32'h7FFFFFFF, 32'h7FFFFFFF);
    check("R7 pos+pos", {result, zero, ovf}, {32'hFFFFFFFE, 1'b0, 1'b1});
    apply(3'b101, 32'h7FFFFFFF, 32'h7FFFFFFF);
    check("R10 code 101", {result, zero, ovf}, {32'h0, 1'b1, 1'b0});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule